// File: doc/BRIEF.md
# Load-Feedback Request Throttle

This block sits on the host side of a link to a memory device and limits how fast requests are issued to that device. Each response that returns from the device carries a 2-bit load report. The block keeps the worst load reported during a fixed adjustment window. Local egress congestion can raise that value. At the end of each window the block moves a 3-bit throttle level up or down by a step that depends on the value it kept.

The throttle level acts as a duty cycle on a valid/ready pass-through. At level k, requests may pass in 8-k cycles out of every 8. At level 0 the path is fully open. The window length is an input. It should be set a little longer than the round trip from host to device and back, so that each step can see the effect of the step before it.

Top module: `load_throttle`

## Requirements
- R1: The load field is encoded 0 = Light, 1 = Optimal, 2 = Moderate, 3 = Severe. A window is judged by the highest value carried by any response in it, so a lighter report after a heavier one in the same window does not lower the result.
- R2: At a window boundary, a window result of Severe raises the level by 2. Moderate raises it by 1, Optimal leaves it unchanged, and Light lowers it by 1.
- R3: The level saturates at 7 when rising and at 0 when falling.
- R4: A window spans `win_len` cycles, and the first window starts with the first clock after reset is released. A response in the final cycle of a window still counts toward that window. The new level appears on `thr_lvl` in the cycle after the final cycle, and it changes at no other time.
- R5: A window in which no response arrives is judged Optimal.
- R6: The kept maximum starts again from Light in each new window, so a heavy report never carries over into the next window.
- R7: If `egress_bp` is high in more than half the cycles of a window (2 x count > `win_len`), the window result is at least Moderate. A count of exactly half has no effect.
- R8: At level k, requests may pass in exactly 8-k of any 8 consecutive cycles.
- R9: `req_out_vld` is `req_in_vld` gated by the current issue slot, and `req_in_rdy` is `req_out_rdy` gated by the same slot. Neither output is ever high when its source is low.
- R10: During and directly after reset the level is 0 and requests pass ungated.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_len | input | CW | Window length in cycles |
| rsp_vld | input | 1 | A response with a load report arrives |
| rsp_load | input | 2 | Load report (0 Light .. 3 Severe) |
| egress_bp | input | 1 | Local egress port is congested this cycle |
| req_in_vld | input | 1 | Upstream request valid |
| req_in_rdy | output | 1 | Ready returned upstream |
| req_out_vld | output | 1 | Request valid toward the device |
| req_out_rdy | input | 1 | Ready from the device side |
| thr_lvl | output | LW | Current throttle level |

## Verification
The hardest condition to reach from the ports is the edge of the congestion rule. The back-pressure count has to land exactly on half a window in one run and one cycle above half in another. In the run just above half, the count must combine with response loads both below and above Moderate. The stimulus aligns every window to the release of reset and holds `egress_bp` for an exact number of leading cycles. It also places responses on the first and last cycle of a window, which exercises the boundary timing. The level is then driven to both ends of its range so that saturation and the gating duty cycle can be seen at level 7.

// File: rtl/load_throttle.sv
module load_throttle #(
  parameter int CW = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] win_len,
  input  logic          rsp_vld,
  input  logic [1:0]    rsp_load,
  input  logic          egress_bp,
  input  logic          req_in_vld,
  output logic          req_in_rdy,
  output logic          req_out_vld,
  input  logic          req_out_rdy,
  output logic [LW-1:0] thr_lvl
);
  localparam logic [LW+1:0] TOP = {2'b00, {LW{1'b1}}};
  localparam logic [1:0] LD_LIGHT = 2'd0;
  localparam logic [1:0] LD_OPT   = 2'd1;
  localparam logic [1:0] LD_MOD   = 2'd2;
  localparam logic [1:0] LD_SEV   = 2'd3;

  logic [CW-1:0] wcnt, bpcnt;
  logic [1:0]    wmax, eff;
  logic          seen;
  logic [LW-1:0] lvl, ph, nxt;
  logic [LW+1:0] up;

  wire          bnd      = ({1'b0, wcnt} + (CW+1)'(1)) >= {1'b0, win_len};
  wire [1:0]    mx_now   = (rsp_vld && rsp_load > wmax) ? rsp_load : wmax;
  wire          seen_now = seen | rsp_vld;
  wire [CW:0]   bp_now   = {1'b0, bpcnt} + (CW+1)'(egress_bp);
  wire          bp_hi    = {bp_now, 1'b0} > {2'b00, win_len};
  wire          allow    = ph >= lvl;

  always_comb begin
    eff = seen_now ? mx_now : LD_OPT;
    if (bp_hi && eff < LD_MOD) eff = LD_MOD;
    up = {2'b00, lvl};
    if (eff == LD_SEV) up = up + (LW+2)'(2);
    else if (eff == LD_MOD) up = up + (LW+2)'(1);
    if (eff == LD_LIGHT) nxt = (lvl == '0) ? '0 : lvl - 1'b1;
    else nxt = (up > TOP) ? TOP[LW-1:0] : up[LW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      bpcnt <= '0;
      wmax  <= LD_LIGHT;
      seen  <= 1'b0;
      lvl   <= '0;
      ph    <= '0;
    end else begin
      ph <= ph + 1'b1;
      if (bnd) begin
        wcnt  <= '0;
        bpcnt <= '0;
        wmax  <= LD_LIGHT;
        seen  <= 1'b0;
        lvl   <= nxt;
      end else begin
        wcnt  <= wcnt + 1'b1;
        bpcnt <= bp_now[CW-1:0];
        wmax  <= mx_now;
        seen  <= seen_now;
      end
    end
  end

  assign req_out_vld = req_in_vld & allow;
  assign req_in_rdy  = req_out_rdy & allow;
  assign thr_lvl     = lvl;

  a_r4_moves_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bnd) |-> $stable(thr_lvl));
  a_r2_step_within_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(thr_lvl) <= int'($past(thr_lvl)) + 2) && (int'(thr_lvl) + 1 >= int'($past(thr_lvl))));
  a_r9_vld_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    req_out_vld |-> req_in_vld);
  a_r9_rdy_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    req_in_rdy |-> req_out_rdy);
  a_r10_open_at_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_lvl == '0) |-> (req_out_vld == req_in_vld));
endmodule

// File: tb/sim_load_throttle.sv
module sim_load_throttle;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] win_len = 16'd16;
  logic rsp_vld = 0, egress_bp = 0, req_in_vld = 0, req_out_rdy = 0;
  logic [1:0] rsp_load = 0;
  logic req_in_rdy, req_out_vld;
  logic [2:0] thr_lvl;
  int checks = 0, fails = 0, exp_lvl = 0, tlen = 16;
  int expq[$];
  string tagq[$];

  always #2.5 clk = ~clk;

  load_throttle u0 (.clk(clk), .rst_n(rst_n), .win_len(win_len), .rsp_vld(rsp_vld),
    .rsp_load(rsp_load), .egress_bp(egress_bp), .req_in_vld(req_in_vld),
    .req_in_rdy(req_in_rdy), .req_out_vld(req_out_vld), .req_out_rdy(req_out_rdy),
    .thr_lvl(thr_lvl));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: the level after a window's last cycle is compared just past that edge
  initial forever begin
    @(posedge clk); #1;
    if (expq.size() > 0) check(tagq.pop_front(), int'(thr_lvl), expq.pop_front());
  end

  // la/lb: response loads (-1 none) at cycles ta/tb; nbp leading bp cycles; mode 0 idle, 1 gate count, 2 blocked
  task automatic run_win(input string tag, input int la, input int ta, input int lb, input int tb,
                         input int nbp, input int mode);
    int mx = -1, eff, nv = 0, nr = 0, bad = 0, k = exp_lvl;
    if (la > mx) mx = la;
    if (lb > mx) mx = lb;
    eff = (mx < 0) ? 1 : mx;
    if (2 * nbp > tlen && eff < 2) eff = 2;
    case (eff)
      3: exp_lvl = (exp_lvl + 2 > 7) ? 7 : exp_lvl + 2;
      2: exp_lvl = (exp_lvl + 1 > 7) ? 7 : exp_lvl + 1;
      0: exp_lvl = (exp_lvl == 0) ? 0 : exp_lvl - 1;
      default: ;
    endcase
    for (int i = 0; i < tlen; i++) begin
      rsp_vld = (la >= 0 && i == ta) || (lb >= 0 && i == tb);
      rsp_load = (la >= 0 && i == ta) ? la[1:0] : lb[1:0];
      egress_bp = (i < nbp);
      req_in_vld = (mode == 1);
      req_out_rdy = (mode == 1);
      if (mode == 2) begin req_in_vld = (i % 2 == 0); req_out_rdy = (i % 2 == 1); end
      #1;
      if (req_out_vld) nv++;
      if (req_in_rdy) nr++;
      if (mode == 2 && ((req_out_vld && !req_in_vld) || (req_in_rdy && !req_out_rdy))) bad++;
      if (i == tlen - 1) begin expq.push_back(exp_lvl); tagq.push_back(tag); end
      @(negedge clk);
    end
    rsp_vld = 0; egress_bp = 0;
    if (mode == 1) begin
      check("R8 issue slots per 16 cycles", nv, 2 * (8 - k));
      check("R9 ready slots match valid slots", nr, 2 * (8 - k));
    end
    if (mode == 2) check("R9 outputs never high without source", bad, 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    req_in_vld = 1; req_out_rdy = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R10 level in reset", int'(thr_lvl), 0);
    check("R10 ungated in reset", int'(req_out_vld) + int'(req_in_rdy), 2);
    @(negedge clk); rst_n = 1;
    run_win("R2 severe +2",          3, 3, -1, 0, 0, 0);   // 2
    run_win("R1 window max kept",    2, 5, 0, 9, 0, 0);    // 3
    run_win("R5 empty holds",       -1, 0, -1, 0, 0, 1);   // 3, gate 10
    run_win("R4 last-cycle counts",  0, 15, -1, 0, 0, 0);  // 2
    run_win("R2 optimal holds",      0, 0, 1, 7, 0, 0);    // 2
    run_win("R2 severe again",       3, 0, -1, 0, 0, 0);   // 4
    run_win("R2 severe to 6",        3, 8, -1, 0, 0, 2);   // 6
    run_win("R3 saturate high",      3, 1, -1, 0, 0, 0);   // 7
    run_win("R3 stays at 7",         3, 2, 3, 4, 0, 0);    // 7
    run_win("R8 hold at 7",         -1, 0, -1, 0, 0, 1);   // 7, gate 2
    run_win("R6 max restarts",       0, 0, -1, 0, 0, 0);   // 6
    for (int j = 0; j < 6; j++) run_win("R2 light -1", 0, j, -1, 0, 0, 0); // 0
    run_win("R3 saturate low",       0, 4, -1, 0, 0, 0);   // 0
    run_win("R8 open at 0",         -1, 0, -1, 0, 0, 1);   // 0, gate 16
    run_win("R7 half bp no effect", -1, 0, -1, 0, 8, 0);   // 0
    run_win("R7 bp over half",      -1, 0, -1, 0, 9, 0);   // 1
    run_win("R7 bp with light",      0, 12, -1, 0, 9, 0);  // 2
    run_win("R7 bp with severe",     3, 12, -1, 0, 9, 0);  // 4
    run_win("R2 moderate +1",        2, 6, -1, 0, 0, 1);   // 5, gate 8
    run_win("R8 at level 5",        -1, 0, -1, 0, 0, 1);   // 5, gate 6
    rst_n = 0; win_len = 16'd10; tlen = 10; exp_lvl = 0;
    repeat (2) @(negedge clk);
    #1;
    check("R10 level after re-reset", int'(thr_lvl), 0);
    @(negedge clk); rst_n = 1;
    run_win("R4 ten-cycle window",   3, 9, -1, 0, 0, 0);   // 2
    run_win("R7 bp 6 of 10",        -1, 0, -1, 0, 6, 0);   // 3
    run_win("R7 bp 5 of 10",        -1, 0, -1, 0, 5, 0);   // 3
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule